// File: doc/BRIEF.md
# Strobe-Referenced Interval Timer

This block measures elapsed time, in system clock cycles, against an external sample-and-hold strobe. Two strobe lines arrive asynchronously. Each line passes through a two-flop synchronizer. A select input then picks which synchronized line is used. Only a rising edge of the picked line counts as a measurement event.

A mode input chooses one of two measurements. In latency mode, a filter-update pulse restarts a 16-bit counter. The running count is captured into the result register at each following strobe rise, which gives the time from the last update to the latest strobe. In period mode, each strobe rise captures the count and restarts it, which gives the spacing between consecutive rises. The counter saturates instead of wrapping. A valid flag marks a fresh result until it is read.

Top module: `sh_timer`

## Requirements
- R1: After reset, `result` is 0 and `result_vld` is 0.
- R2: With `sel_b`=0 only `sh_a` is a measurement source, and with `sel_b`=1 only `sh_b`. Activity on the unselected line changes neither `result` nor `result_vld`.
- R3: Only a rising edge of the selected line causes a capture. A falling edge leaves `result` and `result_vld` unchanged.
- R4: In latency mode (`period_mode`=0), suppose `upd` is sampled high at clock edge U and the selected strobe is first sampled high at edge S, with S > U. The captured result is then S − U + 2, which includes two cycles of synchronizer delay. It is visible after edge S+2.
- R5: In latency mode, further strobe rises without a new `upd` pulse keep measuring from the same update. The second capture equals S2 − U + 2.
- R6: In period mode (`period_mode`=1), suppose two consecutive selected rises are first sampled high at edges S1 and S2. The second capture is then S2 − S1.
- R7: In period mode, `upd` pulses have no effect on the measured period.
- R8: The counter saturates at 0xFFFF. Any interval longer than that is reported as 0xFFFF.
- R9: `result_vld` rises on every capture and clears on a cycle where `rd` is high. When a capture and a read fall in the same cycle, the flag stays set.
- R10: `result` changes only on a capture and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sh_a | input | 1 | Strobe line A (asynchronous) |
| sh_b | input | 1 | Strobe line B (asynchronous) |
| sel_b | input | 1 | 0 selects line A, 1 selects line B |
| period_mode | input | 1 | 0 latency from update, 1 strobe period |
| upd | input | 1 | Filter-update pulse, one cycle |
| rd | input | 1 | Result read strobe, clears the valid flag |
| result | output | CW | Last captured count |
| result_vld | output | 1 | A capture has occurred since the last read |

## Verification
In latency mode the bench varies the update-to-strobe gap at random. During the gap it sometimes raises the unselected line, which separates correct source selection from a design that listens to both lines. Repeated strobes after a single update tell a counter that keeps running apart from one that clears on capture. In period mode the bench drives random rise spacings with stray `upd` pulses mixed in, which exposes any restart on the wrong event. Directed cases cover falling edges, a gap long enough to saturate the counter, and a read that coincides with a capture.

// File: rtl/sh_timer.sv
module sh_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sh_a,
  input  logic          sh_b,
  input  logic          sel_b,
  input  logic          period_mode,
  input  logic          upd,
  input  logic          rd,
  output logic [CW-1:0] result,
  output logic          result_vld
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CONE = CW'(1);

  logic [1:0]    sync_a, sync_b;
  logic          prev;
  logic [CW-1:0] cnt;
  logic          cur, cap, restart;

  assign cur     = sel_b ? sync_b[1] : sync_a[1];
  assign cap     = cur & ~prev;
  assign restart = period_mode ? cap : upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev   <= 1'b0;
    end else begin
      sync_a <= {sync_a[0], sh_a};
      sync_b <= {sync_b[0], sh_b};
      prev   <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= CONE;
    else if (cnt != CMAX)   cnt <= cnt + CONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_vld <= 1'b0;
    end else begin
      if (cap) result <= cnt;
      if (cap)     result_vld <= 1'b1;
      else if (rd) result_vld <= 1'b0;
    end
  end

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !restart) |=> cnt == CMAX);
  a_r9_set_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> result_vld);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cap) |=> !result_vld);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(result));
  a_r6_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (period_mode && cap) |=> cnt == CONE);
  a_r4_update_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_mode && upd) |=> cnt == CONE);
endmodule

// File: tb/tb_sh_timer.sv
`timescale 1ns/1ps
module tb_sh_timer;
  localparam int CW = 16;
  logic clk = 0, rst_n = 0;
  logic sh_a = 0, sh_b = 0, sel_b = 0, period_mode = 0, upd = 0, rd = 0;
  logic [CW-1:0] result;
  logic result_vld;
  int cyc = 0, n_chk = 0, n_bad = 0;

  sh_timer #(.CW(CW)) dut (.clk(clk), .rst_n(rst_n), .sh_a(sh_a), .sh_b(sh_b),
    .sel_b(sel_b), .period_mode(period_mode), .upd(upd), .rd(rd),
    .result(result), .result_vld(result_vld));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int lat_exp(int s, int u);
    return (s - u + 2 > 65535) ? 65535 : s - u + 2;
  endfunction
  function automatic int per_exp(int s2, int s1);
    return (s2 - s1 > 65535) ? 65535 : s2 - s1;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(bit which, logic v);
    if (which) sh_b = v; else sh_a = v;
  endtask

  task automatic pulse_upd(output int t);
    @(negedge clk); upd = 1; t = cyc + 1;
    @(negedge clk); upd = 0;
  endtask

  task automatic strobe(bit which, int hi, output int t);
    @(negedge clk); set_line(which, 1); t = cyc + 1;
    tick(hi);
    set_line(which, 0);
  endtask

  task automatic do_read(string req);
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    check(req, result_vld, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int u, s, s1, s2, hold;
    void'($urandom(32'h5EED_0042));
    tick(4);
    check("R1 result", result, 0);
    check("R1 vld", result_vld, 0);
    rst_n = 1;
    tick(3);

    for (int i = 0; i < 30; i++) begin
      bit which = 1'($urandom_range(0, 1));
      int g = $urandom_range(0, 200);
      sel_b = which;
      tick(2);
      pulse_upd(u);
      set_line(!which, 1'($urandom_range(0, 1)));
      tick(g);
      strobe(which, 3 + $urandom_range(0, 4), s);
      check("R4 latency", result, lat_exp(s, u));
      check("R9 vld set", result_vld, 1);
      set_line(!which, 0);
      do_read("R9 read clears");
      tick(3);
    end

    sel_b = 0;
    tick(3);
    pulse_upd(u);
    tick(10);
    strobe(0, 3, s1);
    check("R4 first", result, lat_exp(s1, u));
    do_read("R9 read");
    hold = result;
    tick(5);
    check("R3 falling no capture", result_vld, 0);
    check("R10 result held", result, hold);
    strobe(0, 3, s2);
    check("R5 second capture", result, lat_exp(s2, u));
    do_read("R9 read");
    tick(3);

    hold = result;
    sh_b = 1; tick(6); sh_b = 0; tick(6);
    check("R2 unselected vld", result_vld, 0);
    check("R2 unselected result", result, hold);

    period_mode = 1;
    sel_b = 1;
    tick(3);
    strobe(1, 3, s1);
    do_read("R9 read");
    for (int i = 0; i < 25; i++) begin
      int lo = $urandom_range(3, 300);
      if ($urandom_range(0, 1) == 1 && lo > 6) begin
        tick(lo / 2);
        pulse_upd(u);
        tick(lo - lo / 2 - 2);
      end else tick(lo);
      strobe(1, 3 + $urandom_range(0, 5), s2);
      check("R6/R7 period", result, per_exp(s2, s1));
      do_read("R9 read");
      s1 = s2;
    end

    tick(2);
    @(negedge clk); sh_b = 1; s = cyc + 1;
    tick(2);
    rd = 1;
    tick(1);
    rd = 0;
    check("R9 capture beats read", result_vld, 1);
    check("R6 period at same-cycle read", result, per_exp(s, s1));
    tick(2); sh_b = 0;
    s1 = s;
    tick(70000);
    strobe(1, 3, s2);
    check("R8 saturate", result, 65535);
    check("R8 expected formula", per_exp(s2, s1), 65535);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule